// File: doc/BRIEF.md
# Two-Stage 128x Audio Decimator

This block turns one channel of an oversampled modulator stream into PCM audio at the final sample rate. Input samples arrive at 128 times the output rate, each marked by a valid strobe. Cycles without the strobe are idle, so the input may arrive in bursts or with gaps.

The rate is reduced in two stages. First, a third-order sinc (CIC) stage divides the rate by 16. Its integrators wrap in two's-complement arithmetic, and they are 12 bits wider than the input. Next come three identical half-band FIR stages in cascade. Each one halves the rate and spends no work on its zero-valued odd taps. The last stage rounds its result and saturates it to a 20-bit signed sample, which leaves with a one-cycle valid pulse.

Each half-band tap set sums to 512, and each stage shifts right by 9, so a constant input passes through every stage without error. A constant input code `x` settles to the output value `x * 65536`: the CIC gain is 4096 and the final alignment into 20 bits is ×16.

Top module: `dec128_chain`

## Requirements
- R1: While reset is held, and until the first output is produced, `out_valid` is 0 and `out_sample` is 0.
- R2: Exactly one output is produced for every 128 accepted inputs. The sinc stage emits one result for every 16 accepted inputs.
- R3: A constant input code `x`, held long enough, produces an output equal to `x * 65536` exactly. For example, 5 gives 327680 and -3 gives -196608.
- R4: `out_valid` is a single-cycle pulse and is never high on two consecutive cycles.
- R5: An input stream that has been all zeros since reset produces only zero-valued outputs.
- R6: Cycles with `in_valid` low are ignored. The value on `in_sample` during such cycles has no effect on any output.
- R7: `out_valid` goes high in the cycle after the third rising edge that follows the edge accepting the 128th input of a group. Each stage adds one register.
- R8: The most negative constant input, -8, produces -524288, the 20-bit minimum, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | IN_W (4) | Signed modulator sample |
| out_valid | output | 1 | Output sample strobe, one cycle wide |
| out_sample | output | OUT_W (20) | Signed rounded and saturated PCM sample |

## Verification
The checker watches several behaviours on every cycle:
- the valid pulses stay one cycle wide;
- the sinc stage fires only on an input that completes a group of 16;
- each stage's valid follows the previous stage's valid by one cycle;
- an all-zero history yields zero outputs.

The bench scenarios cover what only a full run can show:
- the exact settled DC values, including the negative full-scale case;
- settling again after a step between two levels;
- the output count over long runs;
- the three-edge latency;
- the proof that gapped, garbage-filled idle cycles leave the result unchanged.

// File: rtl/dec_pkg.sv
package dec_pkg;
  // Half-band prototype: taps 0..10, odd taps other than the centre are zero.
  // Symmetric, sum = 512, so a shift by HB_SH gives unity DC gain.
  localparam int HB_TAPS = 11;
  localparam int HB_C0   = 3;
  localparam int HB_C2   = -25;
  localparam int HB_C4   = 150;
  localparam int HB_C5   = 256;
  localparam int HB_SH   = 9;
  localparam int HB_NSTG = 3;
endpackage

// File: rtl/dec_cic3.sv
module dec_cic3 #(
  parameter  int IN_W  = 4,
  parameter  int LOG_R = 4,
  localparam int DW    = IN_W + 3 * LOG_R
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_v,
  input  logic signed [IN_W-1:0] in_d,
  output logic                 out_v,
  output logic signed [DW-1:0] out_d
);
  logic signed [DW-1:0] i1, i2, i3, i1_n, i2_n, i3_n;
  logic signed [DW-1:0] z1, z2, z3, z1_n, z2_n, z3_n;
  logic signed [DW-1:0] c1, c2, c3, out_d_n;
  logic [LOG_R-1:0]     ph, ph_n;
  logic                 out_v_n;

  always_comb begin
    i1_n = i1; i2_n = i2; i3_n = i3;
    z1_n = z1; z2_n = z2; z3_n = z3;
    c1 = '0; c2 = '0; c3 = '0;
    ph_n    = ph;
    out_v_n = 1'b0;
    out_d_n = out_d;
    if (in_v) begin
      i1_n = i1 + DW'(in_d);
      i2_n = i2 + i1_n;
      i3_n = i3 + i2_n;
      ph_n = ph + 1'b1;
      if (ph == '1) begin
        c1 = i3_n - z1;
        c2 = c1 - z2;
        c3 = c2 - z3;
        z1_n = i3_n;
        z2_n = c1;
        z3_n = c2;
        out_d_n = c3;
        out_v_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i1 <= '0; i2 <= '0; i3 <= '0;
      z1 <= '0; z2 <= '0; z3 <= '0;
      ph <= '0; out_v <= 1'b0; out_d <= '0;
    end else begin
      i1 <= i1_n; i2 <= i2_n; i3 <= i3_n;
      z1 <= z1_n; z2 <= z2_n; z3 <= z3_n;
      ph <= ph_n; out_v <= out_v_n; out_d <= out_d_n;
    end
  end
endmodule

// File: rtl/dec_hb2.sv
module dec_hb2 import dec_pkg::*; #(
  parameter  int IW = 18,
  parameter  int OW = 18,
  parameter  int SH = 9,
  localparam int AW = IW + 10,
  localparam int ND = HB_TAPS - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_v,
  input  logic signed [IW-1:0] in_d,
  output logic                 out_v,
  output logic signed [OW-1:0] out_d
);
  localparam logic signed [AW-1:0] MAXV = AW'((longint'(1) <<< (OW-1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);
  localparam logic signed [AW-1:0] RND  = AW'(longint'(1) <<< (SH-1));

  logic signed [IW-1:0] d [ND];
  logic signed [IW-1:0] d_n [ND];
  logic signed [AW-1:0] acc, sh, res;
  logic signed [OW-1:0] out_d_n;
  logic                 ph, ph_n, out_v_n;

  always_comb begin
    for (int k = 0; k < ND; k++) d_n[k] = d[k];
    ph_n    = ph;
    out_v_n = 1'b0;
    out_d_n = out_d;
    // window: newest = in_d, older samples d[0..9]; only even taps and centre
    acc = AW'(HB_C0 * (32'(in_d) + 32'(d[9]))
            + HB_C2 * (32'(d[1]) + 32'(d[7]))
            + HB_C4 * (32'(d[3]) + 32'(d[5]))
            + HB_C5 * 32'(d[4]));
    sh  = (acc + RND) >>> SH;
    if (sh > MAXV)      res = MAXV;
    else if (sh < MINV) res = MINV;
    else                res = sh;
    if (in_v) begin
      d_n[0] = in_d;
      for (int k = 1; k < ND; k++) d_n[k] = d[k-1];
      ph_n = ~ph;
      if (ph) begin
        out_v_n = 1'b1;
        out_d_n = res[OW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ND; k++) d[k] <= '0;
      ph <= 1'b0; out_v <= 1'b0; out_d <= '0;
    end else begin
      for (int k = 0; k < ND; k++) d[k] <= d_n[k];
      ph <= ph_n; out_v <= out_v_n; out_d <= out_d_n;
    end
  end
endmodule

// File: rtl/dec128_chain.sv
module dec128_chain import dec_pkg::*; #(
  parameter int IN_W  = 4,
  parameter int LOG_R = 4,
  parameter int OUT_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int DW       = IN_W + 3 * LOG_R;
  localparam int HW       = DW + 2;
  localparam int FINAL_SH = HB_SH - (OUT_W - DW);

  logic [1:0]           rs;
  logic                 srst_n;
  logic [HB_NSTG:0]     stage_v;
  logic signed [DW-1:0] cic_d;
  logic signed [HW-1:0] stage_d [HB_NSTG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= '0;
    else        rs <= {rs[0], 1'b1};
  end
  assign srst_n = rs[1];

  dec_cic3 #(.IN_W(IN_W), .LOG_R(LOG_R)) u_cic (
    .clk(clk), .rst_n(srst_n), .in_v(in_valid), .in_d(in_sample),
    .out_v(stage_v[0]), .out_d(cic_d)
  );
  assign stage_d[0] = HW'(cic_d);

  for (genvar k = 0; k < HB_NSTG; k++) begin : g_hb
    if (k < HB_NSTG - 1) begin : g_mid
      dec_hb2 #(.IW(HW), .OW(HW), .SH(HB_SH)) u_hb (
        .clk(clk), .rst_n(srst_n), .in_v(stage_v[k]), .in_d(stage_d[k]),
        .out_v(stage_v[k+1]), .out_d(stage_d[k+1])
      );
    end else begin : g_last
      dec_hb2 #(.IW(HW), .OW(OUT_W), .SH(FINAL_SH)) u_hb (
        .clk(clk), .rst_n(srst_n), .in_v(stage_v[k]), .in_d(stage_d[k]),
        .out_v(stage_v[k+1]), .out_d(out_sample)
      );
    end
  end

  assign out_valid = stage_v[HB_NSTG];
endmodule

// File: rtl/dec128_chain_chk.sv
module dec128_chain_chk #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 20,
  parameter int NSTG  = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic signed [IN_W-1:0]  in_sample,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_sample,
  input logic [NSTG:0]           stage_v
);
  logic [3:0] acc_cnt;
  logic       all_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt  <= '0;
      all_zero <= 1'b1;
    end else begin
      if (in_valid) acc_cnt <= acc_cnt + 1'b1;
      if (in_valid && in_sample != '0) all_zero <= 1'b0;
    end
  end

  // R2: sinc stage result only right after an input completing a group of 16
  p_cic_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stage_v[0] |-> (acc_cnt == 4'd0 && $past(in_valid)));

  // R4: output strobe is one cycle wide
  p_out_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5: zero history gives zero output
  p_zero_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && all_zero) |-> out_sample == '0);

  // R7: each half-band stage fires one cycle after its feeder
  p_stage_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stage_v[1] |-> $past(stage_v[0]));

  p_out_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(stage_v[NSTG-1]));
endmodule

bind dec128_chain dec128_chain_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .NSTG(dec_pkg::HB_NSTG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
  .out_valid(out_valid), .out_sample(out_sample), .stage_v(stage_v)
);

// File: tb/dec128_chain_test.sv
module dec128_chain_test;
  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic signed [3:0] in_sample;
  logic              out_valid;
  logic signed [19:0] out_sample;

  int n_chk, n_fail, n_out;
  logic signed [19:0] last_out;
  logic prev_v, mon_on, zero_bad;

  dec128_chain uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      n_out++;
      last_out = out_sample;
      if (out_sample != 0) zero_bad = 1'b1;
      if (prev_v) chk(1'b0, "R4 consecutive out_valid", 1, 0);
    end
    prev_v = out_valid;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; mon_on = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_out = 0; zero_bad = 1'b0; mon_on = 1'b1;
  endtask

  task automatic feed(input int x, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sample = 4'(x);
      if (gaps) begin
        @(negedge clk);
        in_valid = 1'b0; in_sample = -4'sd8;
        @(negedge clk);
        in_sample = 4'sd7;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sample = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(out_sample == 0, "R1 out_sample in reset", out_sample, 0);
    do_reset();
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0 && out_sample == 0, "R1 idle after reset", out_sample, 0);
  endtask

  task automatic t_zero();
    do_reset();
    feed(0, 1024, 1'b0);
    repeat (6) @(negedge clk);
    chk(n_out == 8, "R2 count for 1024 inputs", n_out, 8);
    chk(!zero_bad, "R5 zero stream gives zero", last_out, 0);
  endtask

  task automatic t_latency();
    bit seen_early;
    do_reset();
    seen_early = 1'b0;
    feed(1, 127, 1'b0);
    repeat (6) @(negedge clk);
    chk(n_out == 0, "R2 no output before 128th input", n_out, 0);
    feed(1, 1, 1'b0);   // ends on the negedge right after the accepting edge
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (k < 3 && out_valid) seen_early = 1'b1;
      if (k == 3) chk(out_valid == 1'b1, "R7 out_valid after 3 edges", out_valid, 1);
    end
    chk(!seen_early, "R7 no early out_valid", seen_early, 0);
  endtask

  task automatic t_dc(input int x, input string tag);
    do_reset();
    feed(x, 24 * 128, 1'b0);
    repeat (6) @(negedge clk);
    chk(n_out == 24, {tag, " R2 count"}, n_out, 24);
    chk(last_out == x * 65536, {tag, " R3 DC value"}, last_out, x * 65536);
  endtask

  task automatic t_step();
    do_reset();
    feed(5, 24 * 128, 1'b0);
    repeat (6) @(negedge clk);
    chk(last_out == 327680, "R3 level 5", last_out, 327680);
    feed(-3, 24 * 128, 1'b0);
    repeat (6) @(negedge clk);
    chk(last_out == -196608, "R3 step to -3", last_out, -196608);
    chk(n_out == 48, "R2 count over step", n_out, 48);
  endtask

  task automatic t_gaps();
    do_reset();
    feed(6, 24 * 128, 1'b1);
    repeat (6) @(negedge clk);
    chk(n_out == 24, "R6 count with gaps", n_out, 24);
    chk(last_out == 393216, "R6 idle garbage ignored", last_out, 393216);
  endtask

  task automatic t_min();
    do_reset();
    feed(-8, 24 * 128, 1'b0);
    repeat (6) @(negedge clk);
    chk(last_out == -524288, "R8 negative full scale", last_out, -524288);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; n_out = 0; prev_v = 1'b0; mon_on = 1'b0;
    zero_bad = 1'b0; last_out = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    t_reset();
    t_zero();
    t_latency();
    t_dc(5, "dc5");
    t_dc(-3, "dc-3");
    t_dc(7, "dc7");
    t_step();
    t_gaps();
    t_min();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule